// File: doc/BRIEF.md
# BCD Seven-Segment Latch Decoder with Brightness Modulation

This block turns a 4-bit binary-coded decimal digit into the seven segment drive signals of one display position. The digit passes through a small store that is transparent while the latch control is low. While the latch control is high, the store keeps the last accepted digit. Because of this, a shared digit bus can be strobed into several instances in turn, one per display position, for time-shared display use.

Three controls act on the segments, in a fixed order of precedence. An active-low lamp test lights every segment. Below it, an active-low blank input darkens the display. The decoded digit comes last. Codes above nine never produce a pattern and leave the display dark.

A free-running 8-bit counter is compared against a duty word. It adds an internal blank pulse that combines with the external blank input, and this lowers the average brightness. Lamp test still overrides the internal blank. The segment outputs are registered and active high.

Top module: `segdisp_latch_decoder`

## Requirements
- R1: While reset is asserted all segment outputs are 0. After reset the store holds code 0, so with the latch control high the first result is the pattern for digit 0.
- R2: Codes 0 to 9 give these patterns on seg[6:0], where bit 0 is segment a and bit 6 is segment g: 0=0x3F, 1=0x06, 2=0x5B, 3=0x4F, 4=0x66, 5=0x6D, 6=0x7C (segment a unlit), 7=0x07, 8=0x7F, 9=0x67 (segment d unlit). The code weights are 8-4-2-1, and code_in[3] is the most significant bit.
- R3: Codes 10 to 15 give seg = 0x00.
- R4: When lamp_test_n is 0, seg = 0x7F whatever the values of blank_n, hold, code_in and duty.
- R5: When lamp_test_n is 1 and blank_n is 0, seg = 0x00 whatever the values of hold and code_in.
- R6: When hold is 0 the decoder uses code_in directly and the store loads it on each clock edge. When hold is 1 the decoder uses the code the store loaded at the last edge where hold was 0, and changes on code_in have no effect.
- R7: Every input change shows on seg exactly one clock cycle later.
- R8: An 8-bit counter starts at 0 after reset and adds 1 on every clock edge, wrapping from 255 to 0. In any cycle where the counter is greater than or equal to duty, the segments are blanked as in R5. With duty = 0 the display stays dark.
- R9: Lamp test overrides the internal blank of R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lamp_test_n | input | 1 | Active-low lamp test, lights all segments |
| blank_n | input | 1 | Active-low blanking |
| hold | input | 1 | 0: store is transparent; 1: store holds its digit |
| code_in | input | 4 | BCD digit, 8-4-2-1 weights |
| duty | input | 8 | Brightness duty word, the number of lit counter states out of 256 |
| seg | output | 7 | Segment outputs, active high; bit 0 = a through bit 6 = g |

## Verification
On every cycle, the assertions check the precedence of the outputs: lamp test gives all segments lit, external blank gives dark, a zero duty word gives dark, and an illegal displayed code gives dark. They also check that the store cannot change while it is holding. The exact glyph for each digit, the hand-off from transparent to holding, and the periodic on/off pattern of the modulator at a middle duty value can only be shown by the bench's scenarios. The bench checks these against its own model of the counter and the store, cycle by cycle, with one cycle of latency.

// File: rtl/segdisp_pkg.sv
package segdisp_pkg;

  localparam int SEG_N = 7;

  typedef logic [SEG_N-1:0] seg_t;

  localparam seg_t SEG_ALL_ON  = '1;
  localparam seg_t SEG_ALL_OFF = '0;

  // Glyph for one decimal digit; bit 0 = segment a ... bit 6 = segment g.
  function automatic seg_t digit_glyph(input logic [3:0] d);
    seg_t g;
    case (d)
      4'd0:    g = 7'h3F;
      4'd1:    g = 7'h06;
      4'd2:    g = 7'h5B;
      4'd3:    g = 7'h4F;
      4'd4:    g = 7'h66;
      4'd5:    g = 7'h6D;
      4'd6:    g = 7'h7C;  // tail-less six
      4'd7:    g = 7'h07;
      4'd8:    g = 7'h7F;
      4'd9:    g = 7'h67;  // tail-less nine
      default: g = SEG_ALL_OFF;
    endcase
    return g;
  endfunction

endpackage

// File: rtl/segdisp_code_store.sv
module segdisp_code_store #(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic [CODE_W-1:0] code_in,
  output logic [CODE_W-1:0] shown_code
);

  logic              load_en;
  logic [CODE_W-1:0] store_q;
  logic [CODE_W-1:0] store_d;

  always_comb begin
    load_en = ~hold;
    store_d = load_en ? code_in : store_q;
    // Transparent while loading, stored value while holding.
    shown_code = load_en ? code_in : store_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) store_q <= '0;
    else        store_q <= store_d;
  end

  AST_HOLD_KEEPS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(store_q));  // R6

endmodule

// File: rtl/segdisp_dimmer.sv
module segdisp_dimmer #(
  parameter int DUTY_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DUTY_W-1:0] duty,
  output logic              dim_blank
);

  logic              cnt_en;
  logic [DUTY_W-1:0] cnt_q;
  logic [DUTY_W-1:0] cnt_d;

  always_comb begin
    cnt_en    = 1'b1;
    cnt_d     = cnt_en ? cnt_q + 1'b1 : cnt_q;
    dim_blank = (cnt_q >= duty);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/segdisp_decode.sv
module segdisp_decode
  import segdisp_pkg::*;
#(
  parameter int CODE_W = 4
) (
  input  logic              lamp_test_n,
  input  logic              blank_n,
  input  logic              dim_blank,
  input  logic [CODE_W-1:0] code,
  output seg_t              seg_next
);

  localparam int MAX_DIGIT = 9;

  logic legal;
  logic dark;

  always_comb begin
    legal = (int'(code) <= MAX_DIGIT);
    dark  = ~blank_n | dim_blank;
    if (!lamp_test_n)  seg_next = SEG_ALL_ON;
    else if (dark)     seg_next = SEG_ALL_OFF;
    else if (!legal)   seg_next = SEG_ALL_OFF;
    else               seg_next = digit_glyph(code[3:0]);
  end

endmodule

// File: rtl/segdisp_latch_decoder.sv
module segdisp_latch_decoder
  import segdisp_pkg::*;
#(
  parameter int CODE_W = 4,
  parameter int DUTY_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lamp_test_n,
  input  logic              blank_n,
  input  logic              hold,
  input  logic [CODE_W-1:0] code_in,
  input  logic [DUTY_W-1:0] duty,
  output logic [SEG_N-1:0]  seg
);

  logic [CODE_W-1:0] shown_code;
  logic              dim_blank;
  seg_t              seg_next;
  seg_t              seg_q;
  logic              out_en;
  logic              out_vld;

  segdisp_code_store #(.CODE_W(CODE_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .hold       (hold),
    .code_in    (code_in),
    .shown_code (shown_code)
  );

  segdisp_dimmer #(.DUTY_W(DUTY_W)) u_dim (
    .clk       (clk),
    .rst_n     (rst_n),
    .duty      (duty),
    .dim_blank (dim_blank)
  );

  segdisp_decode #(.CODE_W(CODE_W)) u_dec (
    .lamp_test_n (lamp_test_n),
    .blank_n     (blank_n),
    .dim_blank   (dim_blank),
    .code        (shown_code),
    .seg_next    (seg_next)
  );

  assign out_en = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q   <= SEG_ALL_OFF;
      out_vld <= 1'b0;
    end else if (out_en) begin
      seg_q   <= seg_next;
      out_vld <= 1'b1;
    end
  end

  assign seg = seg_q;

  AST_LAMP_TEST_LIGHTS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && !$past(lamp_test_n)) |-> (seg == SEG_ALL_ON));  // R4

  AST_BLANK_DARKENS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && $past(lamp_test_n && !blank_n)) |-> (seg == SEG_ALL_OFF));  // R5

  AST_ILLEGAL_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && $past(lamp_test_n && (int'(shown_code) > 9))) |-> (seg == SEG_ALL_OFF));  // R3

  AST_ZERO_DUTY_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && $past(lamp_test_n && (duty == '0))) |-> (seg == SEG_ALL_OFF));  // R8

  AST_RESET_DARK: assert property (@(posedge clk)
    !rst_n |-> (seg == SEG_ALL_OFF));  // R1

endmodule

// File: tb/segdisp_latch_decoder_test.sv
module segdisp_latch_decoder_test;

  typedef struct {
    logic [6:0] exp;
    string      tag;
  } item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lamp_test_n = 1'b1;
  logic       blank_n = 1'b1;
  logic       hold = 1'b1;
  logic [3:0] code_in = 4'd5;
  logic [7:0] duty = 8'd255;
  logic [6:0] seg;

  int checks = 0;
  int failures = 0;
  item_t sb[$];
  logic [7:0] mcnt;
  logic [3:0] mstore;
  bit done = 0;

  segdisp_latch_decoder uut (
    .clk(clk), .rst_n(rst_n), .lamp_test_n(lamp_test_n), .blank_n(blank_n),
    .hold(hold), .code_in(code_in), .duty(duty), .seg(seg)
  );

  always #5 clk = ~clk;

  // Bench model of the modulator counter (R8).
  always @(posedge clk or negedge rst_n)
    if (!rst_n) mcnt <= 8'd0;
    else        mcnt <= mcnt + 8'd1;

  function automatic logic [6:0] glyph(input logic [3:0] d);
    case (d)
      4'd0: return 7'h3F; 4'd1: return 7'h06; 4'd2: return 7'h5B;
      4'd3: return 7'h4F; 4'd4: return 7'h66; 4'd5: return 7'h6D;
      4'd6: return 7'h7C; 4'd7: return 7'h07; 4'd8: return 7'h7F;
      4'd9: return 7'h67;
      default: return 7'h00;
    endcase
  endfunction

  // Driver: applies one cycle of stimulus at the falling edge, pushes the expectation.
  task automatic step(input logic lt, input logic bi, input logic hd,
                      input logic [3:0] c, input logic [7:0] dw, input string note);
    item_t it;
    logic [3:0] eff;
    @(negedge clk);
    lamp_test_n = lt; blank_n = bi; hold = hd; code_in = c; duty = dw;
    eff = hd ? mstore : c;
    if (!lt) begin
      it.exp = 7'h7F; it.tag = (mcnt >= dw) ? "R9" : "R4";
    end else if (!bi) begin
      it.exp = 7'h00; it.tag = "R5";
    end else if (mcnt >= dw) begin
      it.exp = 7'h00; it.tag = "R8";
    end else if (eff > 4'd9) begin
      it.exp = 7'h00; it.tag = "R3";
    end else begin
      it.exp = glyph(eff); it.tag = hd ? "R6" : "R2/R7";
    end
    if (note != "") it.tag = note;
    if (!hd) mstore = c;
    sb.push_back(it);
  endtask

  // Monitor: compares one item per clock, away from the edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        checks++;
        if (seg !== it.exp) begin
          failures++;
          $display("FAIL %s seg=%h expected=%h", it.tag, seg, it.exp);
        end
      end
    end
  end

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    mstore = 4'd0;
    repeat (3) @(negedge clk);
    checks++;
    if (seg !== 7'h00) begin
      failures++;
      $display("FAIL R1 seg=%h expected=00", seg);
    end
    rst_n = 1'b1;
    // R1: store reset to code 0, shown while holding
    step(1, 1, 1, 4'd5, 8'd255, "R1");
    step(1, 1, 1, 4'd7, 8'd255, "R1");
    // R2 / R3 / R7: sweep every code transparently
    for (int k = 0; k < 16; k++) step(1, 1, 0, k[3:0], 8'd255, "");
    for (int k = 15; k >= 0; k--) step(1, 1, 0, k[3:0], 8'd255, "");
    // R6: load 3, then hold while code_in moves
    step(1, 1, 0, 4'd3, 8'd255, "");
    for (int k = 0; k < 6; k++) step(1, 1, 1, 4'(k * 3 + 1), 8'd255, "R6");
    step(1, 1, 0, 4'd9, 8'd255, "");
    step(1, 1, 1, 4'd0, 8'd255, "R6");
    // R4: lamp test over blank, hold and illegal codes
    step(0, 1, 0, 4'd12, 8'd255, "R4");
    step(0, 0, 1, 4'd1, 8'd255, "R4");
    step(0, 0, 0, 4'd15, 8'd0, "R4");
    // R5: blanking over digits
    step(1, 0, 0, 4'd8, 8'd255, "R5");
    step(1, 0, 1, 4'd2, 8'd255, "R5");
    step(1, 1, 1, 4'd4, 8'd255, "R6");
    // R8 / R9: zero duty keeps dark; lamp test still lights
    for (int k = 0; k < 5; k++) step(1, 1, 0, 4'd8, 8'd0, "R8");
    step(0, 1, 0, 4'd8, 8'd0, "R9");
    // R8: mid duty, several full counter periods
    for (int k = 0; k < 600; k++) step(1, 1, 0, 4'(k % 10), 8'd64, "");
    for (int k = 0; k < 300; k++) step(1, 1, 1, 4'd0, 8'd200, "");
    step(1, 1, 0, 4'd0, 8'd255, "");
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule